// File: doc/BRIEF.md
# Four-State Fetch-Execute Controller

This block is the control sequencer of a small multicycle processor. Each instruction takes four steps: Fetch, Decode, Execute and WriteBack, always in that order. The block holds the program counter and the instruction register. It presents the program counter to instruction memory and latches the returned word at the end of Fetch. It raises the data-memory read strobe and the datapath enable in Execute, and the data-memory write strobe in WriteBack. All changes to the program counter are made at the end of WriteBack.

An instruction word is 16 bits wide. Bits [15:8] hold the opcode and bits [7:0] hold an 8-bit operand, which serves as the branch target or the data address. Data memory answers a read in the same cycle the address is issued, so no wait state is needed. A write completes on the clock edge that ends WriteBack.

Top module: `fetch_exec_ctl`

## Requirements
- R1: While rst_ni is low, and on the first sample after it is released, state_o is 0 (Fetch) and pc_o is 0.
- R2: state_o steps 0 (Fetch), 1 (Decode), 2 (Execute), 3 (WriteBack) and then back to 0, advancing by one on every clock, including after HALT.
- R3: imem_addr_o always equals pc_o. The instruction word on instr_i is captured only at the clock edge that ends Fetch.
- R4: dpu_en_o is high only in Execute, and only for LOAD (opcode 0x04) or ALU (opcode 0x07). It is low in Fetch, Decode and WriteBack.
- R5: dmem_rd_o is high only in Execute, and only for LOAD (0x04).
- R6: dmem_wr_o is high only in WriteBack, and only for STORE (0x05). Whenever dmem_rd_o or dmem_wr_o is high, dmem_addr_o carries bits [7:0] of the captured instruction.
- R7: pc_o changes only at the clock edge that ends WriteBack.
- R8: For NOP (0x00), LOAD, STORE and ALU, and for any branch that is not taken, the program counter increments by one modulo 256 at the end of WriteBack.
- R9: JMP (0x01) always loads the operand into the program counter. JC (0x02) loads it when carry_i is high during WriteBack, and JZ (0x03) loads it when zero_i is high during WriteBack.
- R10: HALT (0x06) leaves the program counter unchanged, so the same HALT is fetched again on every pass through the four states.
- R11: Any opcode not listed above behaves as NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_i | input | 16 | Instruction word read from instruction memory |
| carry_i | input | 1 | Carry flag from the datapath |
| zero_i | input | 1 | Zero flag from the datapath |
| imem_addr_o | output | 8 | Instruction memory address |
| dmem_addr_o | output | 8 | Data memory address (the instruction operand) |
| dmem_rd_o | output | 1 | Data memory read strobe |
| dmem_wr_o | output | 1 | Data memory write strobe |
| dpu_en_o | output | 1 | Datapath enable |
| pc_o | output | 8 | Program counter |
| state_o | output | 2 | Current step: 0 Fetch, 1 Decode, 2 Execute, 3 WriteBack |

## Verification
The first directed program is made only of NOPs. It runs long enough for the program counter to wrap from 255 to 0, which separates a correct modulo increment from an early branch or a stuck counter. The second directed program holds a HALT at address 0, which shows that the program counter freezes while the state sequence keeps advancing. The random programs mix every listed opcode with unlisted ones, and the carry and zero flags are drawn anew each cycle. This separates taken from not-taken conditional branches, checks that flags are sampled in WriteBack and not earlier, and checks that the strobes depend on both the step and the opcode.

// File: rtl/fetch_exec_pkg.sv
package fetch_exec_pkg;
  localparam int OP_W = 8;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2,
    ST_WB     = 2'd3
  } ctl_state_e;

  localparam logic [OP_W-1:0] OP_NOP   = 8'h00;
  localparam logic [OP_W-1:0] OP_JMP   = 8'h01;
  localparam logic [OP_W-1:0] OP_JC    = 8'h02;
  localparam logic [OP_W-1:0] OP_JZ    = 8'h03;
  localparam logic [OP_W-1:0] OP_LOAD  = 8'h04;
  localparam logic [OP_W-1:0] OP_STORE = 8'h05;
  localparam logic [OP_W-1:0] OP_HALT  = 8'h06;
  localparam logic [OP_W-1:0] OP_ALU   = 8'h07;

  typedef struct packed {
    logic jmp;
    logic jc;
    logic jz;
    logic load;
    logic store;
    logic halt;
    logic alu;
  } dec_t;
endpackage

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq
  import fetch_exec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  output ctl_state_e state_o
);
  ctl_state_e state_q, state_d;

  always_comb begin
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = ST_EXEC;
      ST_EXEC:   state_d = ST_WB;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/fetch_exec_ir.sv
module fetch_exec_ir
  import fetch_exec_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int INSTR_W = OP_W + ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [OP_W-1:0]    op_o,
  output logic [ADDR_W-1:0]  arg_o,
  output dec_t               dec_o
);
  logic [INSTR_W-1:0] ir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ir_q <= '0;
    else if (load_i) ir_q <= instr_i;
  end

  assign op_o  = ir_q[INSTR_W-1 -: OP_W];
  assign arg_o = ir_q[ADDR_W-1:0];

  always_comb begin
    dec_o       = '0;
    dec_o.jmp   = (op_o == OP_JMP);
    dec_o.jc    = (op_o == OP_JC);
    dec_o.jz    = (op_o == OP_JZ);
    dec_o.load  = (op_o == OP_LOAD);
    dec_o.store = (op_o == OP_STORE);
    dec_o.halt  = (op_o == OP_HALT);
    dec_o.alu   = (op_o == OP_ALU);
  end
endmodule

// File: rtl/fetch_exec_pc.sv
module fetch_exec_pc
  import fetch_exec_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_i,
  input  dec_t              dec_i,
  input  logic [ADDR_W-1:0] arg_i,
  input  logic              carry_i,
  input  logic              zero_i,
  output logic [ADDR_W-1:0] pc_o
);
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              take;

  assign take = dec_i.jmp | (dec_i.jc & carry_i) | (dec_i.jz & zero_i);

  always_comb begin
    pc_d = pc_q;
    if (wb_i) begin
      if (dec_i.halt) pc_d = pc_q;
      else if (take)  pc_d = arg_i;
      else            pc_d = pc_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/fetch_exec_ctl.sv
module fetch_exec_ctl
  import fetch_exec_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int INSTR_W = OP_W + ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               carry_i,
  input  logic               zero_i,
  output logic [ADDR_W-1:0]  imem_addr_o,
  output logic [ADDR_W-1:0]  dmem_addr_o,
  output logic               dmem_rd_o,
  output logic               dmem_wr_o,
  output logic               dpu_en_o,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [1:0]         state_o
);
  ctl_state_e        state;
  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] arg;
  dec_t              dec;
  logic              in_fetch, in_exec, in_wb;

  fetch_exec_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (state)
  );

  assign in_fetch = (state == ST_FETCH);
  assign in_exec  = (state == ST_EXEC);
  assign in_wb    = (state == ST_WB);

  fetch_exec_ir #(.ADDR_W(ADDR_W)) u_ir (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (in_fetch),
    .instr_i (instr_i),
    .op_o    (op),
    .arg_o   (arg),
    .dec_o   (dec)
  );

  fetch_exec_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wb_i    (in_wb),
    .dec_i   (dec),
    .arg_i   (arg),
    .carry_i (carry_i),
    .zero_i  (zero_i),
    .pc_o    (pc_o)
  );

  assign imem_addr_o = pc_o;
  assign dmem_addr_o = arg;
  assign dmem_rd_o   = in_exec & dec.load;
  assign dmem_wr_o   = in_wb & dec.store;
  assign dpu_en_o    = in_exec & (dec.load | dec.alu);
  assign state_o     = state;
endmodule

// File: rtl/fetch_exec_ctl_chk.sv
module fetch_exec_ctl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        state_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic              dmem_rd_o,
  input logic              dmem_wr_o,
  input logic              dpu_en_o,
  input logic [7:0]        ir_op,
  input logic [ADDR_W-1:0] ir_arg
);
  AST_STEP_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> state_o == 2'($past(state_o) + 2'd1)); // R2
  AST_DPU_IN_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dpu_en_o |-> state_o == 2'd2); // R4
  AST_READ_IN_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_rd_o |-> (state_o == 2'd2 && ir_op == 8'h04)); // R5
  AST_WRITE_IN_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_wr_o |-> (state_o == 2'd3 && ir_op == 8'h05)); // R6
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd3 |=> $stable(pc_o)); // R7
  AST_JMP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3 && ir_op == 8'h01) |=> pc_o == $past(ir_arg)); // R9
  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3 && ir_op == 8'h06) |=> $stable(pc_o)); // R10
endmodule

bind fetch_exec_ctl fetch_exec_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .state_o   (state_o),
  .pc_o      (pc_o),
  .dmem_rd_o (dmem_rd_o),
  .dmem_wr_o (dmem_wr_o),
  .dpu_en_o  (dpu_en_o),
  .ir_op     (op),
  .ir_arg    (arg)
);

// File: tb/fetch_exec_ctl_bench.sv
module fetch_exec_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr;
  logic        carry = 1'b0, zero = 1'b0;
  logic [7:0]  imem_addr, dmem_addr, pc;
  logic        rd, wr, dpu;
  logic [1:0]  state;

  logic [15:0] rom [256];
  int checks = 0, errors = 0;
  int cyc = 0;
  logic [1:0]  m_state;
  logic [7:0]  m_pc;
  logic [15:0] m_ir;

  always #10 clk = ~clk;

  assign instr = rom[imem_addr];

  fetch_exec_ctl u_fetch_exec_ctl (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .carry_i(carry), .zero_i(zero),
    .imem_addr_o(imem_addr), .dmem_addr_o(dmem_addr), .dmem_rd_o(rd), .dmem_wr_o(wr),
    .dpu_en_o(dpu), .pc_o(pc), .state_o(state)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [7:0] next_pc(input logic [7:0] p, input logic [15:0] ir,
                                         input logic c, input logic z);
    case (ir[15:8])
      8'h01:   return ir[7:0];
      8'h02:   return c ? ir[7:0] : p + 8'd1;
      8'h03:   return z ? ir[7:0] : p + 8'd1;
      8'h06:   return p;
      default: return p + 8'd1;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 state in reset", 16'(state), 16'd0);
    chk("R1 pc in reset", 16'(pc), 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    m_state = 2'd0; m_pc = 8'd0; m_ir = 16'd0;
  endtask

  // one cycle: check at negedge, set flags, advance model to next posedge
  task automatic step(input bit rnd_flags);
    logic [7:0] op;
    op = m_ir[15:8];
    chk("R2 state", 16'(state), 16'(m_state));
    chk("R7 R8 R9 R10 pc", 16'(pc), 16'(m_pc));
    chk("R3 imem addr", 16'(imem_addr), 16'(m_pc));
    chk("R4 dpu_en", 16'(dpu), 16'(m_state == 2'd2 && (op == 8'h04 || op == 8'h07)));
    chk("R5 dmem_rd", 16'(rd), 16'(m_state == 2'd2 && op == 8'h04));
    chk("R6 dmem_wr", 16'(wr), 16'(m_state == 2'd3 && op == 8'h05));
    if (rd || wr) chk("R6 dmem addr", 16'(dmem_addr), 16'(m_ir[7:0]));
    if (rnd_flags) begin
      carry = 1'($urandom());
      zero  = 1'($urandom());
    end
    if (m_state == 2'd0) m_ir = rom[m_pc];
    if (m_state == 2'd3) m_pc = next_pc(m_pc, m_ir, carry, zero);
    m_state = m_state + 2'd1;
    cyc++;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R8 R11: all NOP, pc wraps 255 -> 0
    for (int i = 0; i < 256; i++) rom[i] = 16'h0000;
    rom[3] = 16'h3A55; // unlisted opcode as NOP, R11
    do_reset();
    for (int i = 0; i < 1040; i++) step(1'b1);
    // R10: HALT at 0 freezes pc, states continue
    for (int i = 0; i < 256; i++) rom[i] = 16'h0000;
    rom[0] = 16'h0612;
    do_reset();
    for (int i = 0; i < 40; i++) step(1'b1);
    // R9: directed branches with fixed flags
    rom[0] = 16'h0240; rom[8'h40] = 16'h0380; rom[8'h41] = 16'h0190;
    rom[8'h90] = 16'h0406; rom[8'h91] = 16'h0507; rom[8'h92] = 16'h0700;
    rom[8'h93] = 16'h0600;
    carry = 1'b1; zero = 1'b0;
    do_reset();
    for (int i = 0; i < 40; i++) step(1'b0);
    // random programs, random flags
    for (int r = 0; r < 25; r++) begin
      for (int i = 0; i < 256; i++) begin
        logic [3:0] k;
        k = 4'($urandom());
        rom[i] = {(k < 4'd8) ? {5'd0, k[2:0]} : {4'h0, k} + 8'h10, 8'($urandom())};
        if (k == 4'd6 && ($urandom() % 4) != 0) rom[i][15:8] = 8'h00;
      end
      do_reset();
      for (int i = 0; i < 400; i++) step(1'b1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule